// File: doc/BRIEF.md
# Background Wide-Block Transfer Engine

This engine moves data between a shared hub memory and a core's private auxiliary RAM. The auxiliary RAM holds 32 blocks of eight 32-bit longs. Each hub slot the engine is granted carries one whole 256-bit block in either direction. A core starts a run with one command. The command gives a hub byte address, a starting block, a block count, a direction and a stall option. The engine then walks through the blocks on its own and uses each grant as it arrives.

Without the stall option the core gives up only the issue cycle and keeps executing while the blocks move. With the stall option the core is held from the cycle after issue until the final block has moved. A command that arrives while a run is in flight is held off, and the core is stalled, until the engine goes idle. Hub arbitration happens outside the block, which only raises a request and consumes grants.

Top module: `wbx_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `hub_req`, `hub_we`, `aux_we` and `core_stall` are all 0.
- R2: A command is taken in any cycle where `cmd_valid` is 1 and `busy` is 0. `busy` reads 1 from the next cycle onward.
- R3: While busy, `hub_req` is 1. One block moves only in a cycle where `hub_gnt` is 1. Without a grant, nothing is written and the hub address and block index hold.
- R4: The first hub address is the command address with its low 5 bits forced to 0. Each later block adds 32 bytes, and the address wraps at the top of the hub space.
- R5: The auxiliary block index starts at the 3-bit start field. It rises by one per block and wraps from 31 to 0.
- R6: The 5-bit count field gives the number of blocks, and 0 means 32. `busy` falls in the cycle after the grant that moves the last block.
- R7: Direction 0 (hub to aux) keeps `hub_we` at 0. In each granted cycle it drives `aux_we` 1 with `aux_wdata` equal to `hub_rdata`.
- R8: Direction 1 (aux to hub) keeps `hub_we` at 1 and `aux_we` at 0, and `hub_wdata` carries `aux_rdata` of the current block.
- R9: With the stall bit set, `core_stall` is 1 from the cycle after acceptance until `busy` falls. With the stall bit clear, the run never raises `core_stall`.
- R10: `cmd_valid` while busy raises `core_stall` in that cycle. That command has no effect until the engine is idle, and then it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Core presents a command |
| cmd_dir | input | 1 | 0 hub to aux, 1 aux to hub |
| cmd_stall | input | 1 | Hold the core until the run ends |
| cmd_addr | input | 18 | Hub byte address (low 5 bits ignored) |
| cmd_blk | input | 3 | Starting auxiliary block |
| cmd_cnt | input | 5 | Block count, 0 means 32 |
| busy | output | 1 | Run in progress |
| core_stall | output | 1 | Core must hold |
| hub_req | output | 1 | Slot request |
| hub_gnt | input | 1 | Slot granted this cycle |
| hub_we | output | 1 | Hub write |
| hub_addr | output | 18 | Hub byte address of the current block |
| hub_wdata | output | 256 | Block to hub |
| hub_rdata | input | 256 | Block from hub, valid in the grant cycle |
| aux_idx | output | 5 | Current auxiliary block |
| aux_we | output | 1 | Auxiliary block write |
| aux_wdata | output | 256 | Block to auxiliary RAM |
| aux_rdata | input | 256 | Auxiliary block at `aux_idx`, combinational |

## Verification
The assertions assume three things about the inputs. Hub read data is valid in the same cycle as the grant. Auxiliary read data follows `aux_idx` with no delay. A grant that arrives with no request is simply ignored. The stimulus keeps to these assumptions: the hub and auxiliary models are combinational functions of the driven address and index, grants are drawn at random every cycle whether or not a request is up, and command fields stay fixed while a command is held off.

// File: rtl/wbx_pkg.sv
package wbx_pkg;
    typedef enum logic {
        WBX_HUB2AUX = 1'b0,
        WBX_AUX2HUB = 1'b1
    } wbx_dir_e;
endpackage

// File: rtl/wbx_cmd_decode.sv
module wbx_cmd_decode #(
    parameter int HUB_AW  = 18,
    parameter int OFF_W   = 5,
    parameter int START_W = 3,
    parameter int CNT_W   = 5,
    parameter int IDX_W   = 5
) (
    input  logic [HUB_AW-1:0]       addr_i,
    input  logic [START_W-1:0]      blk_i,
    input  logic [CNT_W-1:0]        cnt_i,
    output logic [HUB_AW-OFF_W-1:0] base_o,
    output logic [IDX_W-1:0]        idx0_o,
    output logic [CNT_W:0]          count_o
);
    // byte offset inside a block is dropped; the block number carries on
    assign base_o  = addr_i[HUB_AW-1:OFF_W];
    assign idx0_o  = IDX_W'(blk_i);
    // a zero count stands for the full 2**CNT_W blocks
    assign count_o = (cnt_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt_i};
endmodule

// File: rtl/wbx_ctrl.sv
module wbx_ctrl
    import wbx_pkg::*;
#(
    parameter int BA_W  = 13,
    parameter int IDX_W = 5,
    parameter int REM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  wbx_dir_e         dir_i,
    input  logic             hold_i,
    input  logic [BA_W-1:0]  base_i,
    input  logic [IDX_W-1:0] idx0_i,
    input  logic [REM_W-1:0] count_i,
    input  logic             gnt_i,
    output logic             busy_o,
    output wbx_dir_e         dir_o,
    output logic             hold_o,
    output logic [BA_W-1:0]  blk_o,
    output logic [IDX_W-1:0] idx_o
);
    typedef struct packed {
        logic             busy;
        wbx_dir_e         dir;
        logic             hold;
        logic [BA_W-1:0]  blk;
        logic [IDX_W-1:0] idx;
        logic [REM_W-1:0] rem;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.dir  = dir_i;
            s_d.hold = hold_i;
            s_d.blk  = base_i;
            s_d.idx  = idx0_i;
            s_d.rem  = count_i;
        end else if (s_q.busy && gnt_i) begin
            // index width equals log2(blocks): natural wrap 31 -> 0
            s_d.blk = s_q.blk + 1'b1;
            s_d.idx = s_q.idx + 1'b1;
            s_d.rem = s_q.rem - 1'b1;
            if (s_q.rem == REM_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.hold = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign dir_o  = s_q.dir;
    assign hold_o = s_q.hold;
    assign blk_o  = s_q.blk;
    assign idx_o  = s_q.idx;
endmodule

// File: rtl/wbx_engine.sv
module wbx_engine
    import wbx_pkg::*;
#(
    parameter int LONGS   = 8,
    parameter int LONG_W  = 32,
    parameter int BLOCKS  = 32,
    parameter int HUB_AW  = 18,
    parameter int START_W = 3,
    parameter int CNT_W   = 5,
    localparam int DATA_W = LONGS * LONG_W,
    localparam int IDX_W  = $clog2(BLOCKS),
    localparam int OFF_W  = $clog2(DATA_W / 8),
    localparam int BA_W   = HUB_AW - OFF_W,
    localparam int REM_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_dir,
    input  logic              cmd_stall,
    input  logic [HUB_AW-1:0] cmd_addr,
    input  logic [START_W-1:0] cmd_blk,
    input  logic [CNT_W-1:0]  cmd_cnt,
    output logic              busy,
    output logic              core_stall,
    output logic              hub_req,
    input  logic              hub_gnt,
    output logic              hub_we,
    output logic [HUB_AW-1:0] hub_addr,
    output logic [DATA_W-1:0] hub_wdata,
    input  logic [DATA_W-1:0] hub_rdata,
    output logic [IDX_W-1:0]  aux_idx,
    output logic              aux_we,
    output logic [DATA_W-1:0] aux_wdata,
    input  logic [DATA_W-1:0] aux_rdata
);
    logic [BA_W-1:0]  base, blk_cur;
    logic [IDX_W-1:0] idx0;
    logic [REM_W-1:0] count;
    logic             start, hold;
    wbx_dir_e         dir_cur;

    wbx_cmd_decode #(
        .HUB_AW(HUB_AW), .OFF_W(OFF_W), .START_W(START_W),
        .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_dec (
        .addr_i(cmd_addr), .blk_i(cmd_blk), .cnt_i(cmd_cnt),
        .base_o(base), .idx0_o(idx0), .count_o(count)
    );

    assign start = cmd_valid & ~busy;

    wbx_ctrl #(.BA_W(BA_W), .IDX_W(IDX_W), .REM_W(REM_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .dir_i(wbx_dir_e'(cmd_dir)), .hold_i(cmd_stall),
        .base_i(base), .idx0_i(idx0), .count_i(count), .gnt_i(hub_gnt),
        .busy_o(busy), .dir_o(dir_cur), .hold_o(hold),
        .blk_o(blk_cur), .idx_o(aux_idx)
    );

    // wide data passes straight through in the grant cycle
    assign hub_req    = busy;
    assign hub_we     = busy & (dir_cur == WBX_AUX2HUB);
    assign hub_addr   = {blk_cur, {OFF_W{1'b0}}};
    assign hub_wdata  = aux_rdata;
    assign aux_we     = busy & hub_gnt & (dir_cur == WBX_HUB2AUX);
    assign aux_wdata  = hub_rdata;
    assign core_stall = busy & (hold | cmd_valid);
endmodule

// File: rtl/wbx_engine_chk.sv
module wbx_engine_chk #(
    parameter int HUB_AW = 18,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              busy,
    input logic              core_stall,
    input logic              hub_req,
    input logic              hub_gnt,
    input logic              hub_we,
    input logic [HUB_AW-1:0] hub_addr,
    input logic [IDX_W-1:0]  aux_idx,
    input logic              aux_we
);
    // R3: auxiliary writes only in a requested and granted slot
    a_r3_aux_we_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        aux_we |-> (hub_gnt && hub_req));

    // R3: without a grant the current block position holds
    a_r3_hold_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_req && !hub_gnt) |=> ($stable(hub_addr) && $stable(aux_idx) && busy));

    // R5: block index steps by one (mod 32) after each granted block
    a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_req && hub_gnt) |=> (!busy || aux_idx == $past(aux_idx) + 1'b1));

    // R4: hub address advances one block of 32 bytes per grant
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_req && hub_gnt) |=> (!busy || hub_addr == $past(hub_addr) + HUB_AW'(32)));

    // R8: the two directions never write both memories at once
    a_r8_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        hub_we |-> !aux_we);

    // R10: a command offered while busy stalls the core
    a_r10_held_off_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |-> core_stall);

    // R1: reset leaves the engine idle
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !hub_req && !aux_we && !core_stall));
endmodule

bind wbx_engine wbx_engine_chk #(.HUB_AW(HUB_AW), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
    .core_stall(core_stall), .hub_req(hub_req), .hub_gnt(hub_gnt),
    .hub_we(hub_we), .hub_addr(hub_addr), .aux_idx(aux_idx), .aux_we(aux_we)
);

// File: tb/wbx_engine_tb.sv
module wbx_engine_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0, cmd_dir = 1'b0, cmd_stall = 1'b0;
    logic [17:0]  cmd_addr = '0;
    logic [2:0]   cmd_blk = '0;
    logic [4:0]   cmd_cnt = '0;
    logic         busy, core_stall, hub_req, hub_we, aux_we;
    logic         hub_gnt = 1'b0;
    logic [17:0]  hub_addr;
    logic [255:0] hub_wdata, hub_rdata, aux_wdata, aux_rdata;
    logic [4:0]   aux_idx;

    int n_checks = 0, n_fail = 0;
    int gnt_mode = 0;   // 0 always, 1 random, 2 never
    bit accepted;

    typedef struct { logic [17:0] a; logic [4:0] i; } exp_t;
    exp_t q[$];
    bit   m_dir, m_hold;

    always #4 clk = ~clk;

    function automatic logic [255:0] pat_hub(input logic [17:0] a);
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[k*32 +: 32] = {14'h1A5, a} + 32'(k);
        return r;
    endfunction

    function automatic logic [255:0] pat_aux(input logic [4:0] i);
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[k*32 +: 32] = {24'hBEEF00, 3'b0, i} + 32'(k << 8);
        return r;
    endfunction

    assign hub_rdata = pat_hub(hub_addr);
    assign aux_rdata = pat_aux(aux_idx);

    wbx_engine u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        bit b = q.size() > 0;
        bit st = (b && m_hold) || (cmd_valid && b);
        chk(busy === b, "R6", "busy", busy, b);
        chk(hub_req === b, "R3", "hub_req", hub_req, b);
        chk(core_stall === st, "R9", "core_stall", core_stall, st);
        if (b && hub_gnt) begin
            exp_t e = q.pop_front();
            chk(hub_addr === e.a, "R4", "hub_addr", hub_addr, e.a);
            chk(aux_idx === e.i, "R5", "aux_idx", aux_idx, e.i);
            if (m_dir) begin
                chk(hub_we === 1'b1 && aux_we === 1'b0, "R8", "we", {hub_we, aux_we}, 2'b10);
                chk(hub_wdata === pat_aux(e.i), "R8", "hub_wdata", hub_wdata, pat_aux(e.i));
            end else begin
                chk(hub_we === 1'b0 && aux_we === 1'b1, "R7", "we", {hub_we, aux_we}, 2'b01);
                chk(aux_wdata === pat_hub(e.a), "R7", "aux_wdata", aux_wdata, pat_hub(e.a));
            end
        end else begin
            chk(aux_we === 1'b0, "R3", "aux_we without grant", aux_we, 0);
        end
        if (cmd_valid && !b) begin   // R2 acceptance
            int n = (cmd_cnt == 0) ? 32 : int'(cmd_cnt);
            for (int k = 0; k < n; k++) begin
                exp_t e;
                e.a = (cmd_addr & 18'h3FFE0) + 18'(k * 32);
                e.i = 5'(int'(cmd_blk) + k);
                q.push_back(e);
            end
            m_dir = cmd_dir; m_hold = cmd_stall; accepted = 1'b1;
        end
        if (q.size() == 0) m_hold = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        case (gnt_mode)
            0: hub_gnt = 1'b1;
            1: hub_gnt = 1'($urandom_range(0, 1));
            default: hub_gnt = 1'b0;
        endcase
        #1;
        if (rst_n) step();
    endtask

    task automatic issue(input bit dir, input bit stl, input logic [17:0] a,
                         input logic [2:0] blk, input logic [4:0] cnt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dir = dir; cmd_stall = stl;
        cmd_addr = a; cmd_blk = blk; cmd_cnt = cnt;
        accepted = 1'b0;
        #1 step();
        while (!accepted) tick();
        @(posedge clk); #1 cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) tick();
        tick(); tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle after reset, even with a grant offered
        hub_gnt = 1'b1;
        @(posedge clk); #1;
        chk({busy, hub_req, hub_we, aux_we, core_stall} === 5'b0, "R1", "idle outputs",
            {busy, hub_req, hub_we, aux_we, core_stall}, 0);
        rst_n = 1'b1;
        tick(); tick();

        // R2 R7: hub to aux, 3 blocks from block 2, full grants
        gnt_mode = 0;
        issue(1'b0, 1'b0, 18'h00140, 3'd2, 5'd3);
        drain();

        // R4 R5 R6 R8: aux to hub, count 0 = 32 blocks, low address bits ignored
        gnt_mode = 1;
        issue(1'b1, 1'b0, 18'h01237, 3'd7, 5'd0);
        drain();

        // R9 R5 R4: stall run crossing block 31 and the top of hub space
        issue(1'b0, 1'b1, 18'h3FFC0, 3'd5, 5'd30);
        drain();

        // R10: second command offered while the first runs is held off
        issue(1'b1, 1'b0, 18'h02000, 3'd1, 5'd4);
        issue(1'b0, 1'b0, 18'h03000, 3'd6, 5'd2);
        drain();

        // R3: no grants for a while in mid-run, then grants resume
        gnt_mode = 0;
        issue(1'b1, 1'b1, 18'h00400, 3'd3, 5'd5);
        gnt_mode = 2;
        repeat (10) tick();
        gnt_mode = 1;
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule